// File: doc/BRIEF.md
# Vector Mask Compare and Masked Execute Unit

This block pairs a mask register (one bit per vector element) with an element-serial integer vector engine. The engine works on a small bank of vector registers and handles one element per clock. A compare command sets the mask bits from an element-wise comparison. The comparison is made either between two vector registers or between a vector register and a scalar. An arithmetic command (add or subtract, vector-vector or vector-scalar) can be issued masked. A masked command writes only the elements whose mask bit is 1 and leaves the other elements as they were. Masked-off elements still take their cycle, so the run time depends only on the active vector length.

A controller issues one command at a time on the command port while the unit is idle. Commands that do not touch elements finish in a single cycle:
- mask clear (all ones)
- mask load from a scalar
- set vector length

Every command reports completion with a one-cycle done pulse. A host port loads and reads single vector elements while the unit is idle. That port is how operands are supplied and results are observed.

Top module: `vmask_unit`

## Requirements
- R1: A compare command (cmd_op 4 = vector-vector, 5 = vector-scalar) sets mask bit i, for every i below the vector length, to 1 when the condition on element i holds and to 0 when it does not. The command ignores cmd_masked.
- R2: Condition codes on cmd_cond treat elements as two's-complement signed values. The codes are 0 = equal, 1 = not equal, 2 = greater, 3 = less, 4 = greater-or-equal, 5 = less-or-equal. The left operand is vector register cmd_va.
- R3: A masked arithmetic command (cmd_masked = 1) writes destination element i only where mask bit i is 1.
- R4: Elements whose mask bit is 0 keep their previous value under a masked command. An unmasked command writes every element below the vector length whatever the mask holds.
- R5: cmd_op 6 sets all mask bits to 1.
- R6: cmd_op 7 loads cmd_scalar into the mask register, with bit i going to mask bit i.
- R7: An element command keeps busy high for exactly vector-length cycles, whatever the mask holds.
- R8: Elements at or above the vector length are never written, and a compare leaves mask bits at or above the vector length unchanged.
- R9: done is high for exactly one cycle, in the cycle after the last element is processed. With a vector length of 0, an element command raises done in the cycle after it is accepted and writes nothing.
- R10: After reset the mask is all ones, the vector length is MVL and every element is 0. cmd_op 8 sets the vector length to cmd_scalar, clamped at MVL.
- R11: Arithmetic wraps modulo 2^EW. The operation codes are 0 = va+vb, 1 = va-vb, 2 = va+scalar and 3 = va-scalar, with the scalar taken from cmd_scalar[EW-1:0].
- R12: While busy is high, commands and host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 4 | Operation code |
| cmd_cond | input | 3 | Compare condition code |
| cmd_masked | input | 1 | Apply mask to arithmetic |
| cmd_vd | input | RW | Destination vector register |
| cmd_va | input | RW | First source vector register |
| cmd_vb | input | RW | Second source vector register |
| cmd_scalar | input | MVL | Scalar operand, mask image or new length |
| busy | output | 1 | Element processing in progress |
| done | output | 1 | One-cycle completion pulse |
| mask_q | output | MVL | Current mask register |
| vl_q | output | VLW | Current vector length |
| host_we | input | 1 | Host element write strobe |
| host_reg | input | RW | Host write register |
| host_idx | input | IDXW | Host write element index |
| host_wdata | input | EW | Host write data |
| host_rreg | input | RW | Host read register |
| host_ridx | input | IDXW | Host read element index |
| host_rdata | output | EW | Host read data (combinational) |

## Verification
The embedded properties check the following on every cycle:
- the element index stays below the vector length during a run;
- done follows the final element by one cycle;
- the mask is stable during arithmetic runs;
- a clear gives all ones and a mask load copies the scalar;
- the length never exceeds MVL.

Only the bench scenarios can show that the right elements hold the right values. That covers the compare outcomes across all six conditions and their signed boundaries, the kept values under masked subtract, wrap-around, and that writes beyond the length or during busy leave storage untouched.

// File: rtl/vmask_pkg.sv
`timescale 1ns/1ps
// vmask_pkg: operation and condition encodings shared by the mask unit.
// Assumes cmd_op is 4 bits and cmd_cond is 3 bits wide at the top level.
package vmask_pkg;

    typedef enum logic [3:0] {
        OP_VADD  = 4'd0,
        OP_VSUB  = 4'd1,
        OP_VADDS = 4'd2,
        OP_VSUBS = 4'd3,
        OP_CMPV  = 4'd4,
        OP_CMPS  = 4'd5,
        OP_CLRM  = 4'd6,
        OP_MOVM  = 4'd7,
        OP_SETVL = 4'd8
    } vop_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_GT = 3'd2,
        CC_LT = 3'd3,
        CC_GE = 3'd4,
        CC_LE = 3'd5
    } vcond_e;

    // True for operations that write vector elements.
    function automatic logic op_is_arith(vop_e op);
        return (op == OP_VADD) || (op == OP_VSUB) || (op == OP_VADDS) || (op == OP_VSUBS);
    endfunction

    // True for operations that write mask bits element by element.
    function automatic logic op_is_cmp(vop_e op);
        return (op == OP_CMPV) || (op == OP_CMPS);
    endfunction

    // True for operations whose second operand is the scalar.
    function automatic logic op_uses_scalar(vop_e op);
        return (op == OP_VADDS) || (op == OP_VSUBS) || (op == OP_CMPS);
    endfunction

    // True for subtracting operations.
    function automatic logic op_is_sub(vop_e op);
        return (op == OP_VSUB) || (op == OP_VSUBS);
    endfunction

endpackage

// File: rtl/vmask_cmp.sv
`timescale 1ns/1ps
// vmask_cmp: signed element comparator producing one mask bit.
// Assumes two's-complement operands; unknown condition codes yield 0.
module vmask_cmp
    import vmask_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic [EW-1:0] lhs,
    input  logic [EW-1:0] rhs,
    input  logic [2:0]    cond,
    output logic          hit
);

    logic signed [EW-1:0] sl;
    logic signed [EW-1:0] sr;

    assign sl = $signed(lhs);
    assign sr = $signed(rhs);

    // Select the comparison named by the condition code.
    always_comb begin
        unique case (vcond_e'(cond))
            CC_EQ:   hit = (sl == sr);
            CC_NE:   hit = (sl != sr);
            CC_GT:   hit = (sl >  sr);
            CC_LT:   hit = (sl <  sr);
            CC_GE:   hit = (sl >= sr);
            CC_LE:   hit = (sl <= sr);
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/vmask_alu.sv
`timescale 1ns/1ps
// vmask_alu: element adder/subtractor, wraps modulo 2^EW.
// Assumes operand selection (vector or scalar) happens upstream.
module vmask_alu #(
    parameter int EW = 16
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic          sub,
    output logic [EW-1:0] y
);

    // Single add/subtract path; overflow is discarded.
    always_comb begin
        if (sub) y = a - b;
        else     y = a + b;
    end

endmodule

// File: rtl/vmask_rf.sv
`timescale 1ns/1ps
// vmask_rf: NREG vector registers of MVL elements, one write port and
// three combinational read ports (two for the engine, one for the host).
// Assumes NREG and MVL are powers of two so {reg,idx} forms the address.
module vmask_rf #(
    parameter int MVL  = 64,
    parameter int EW   = 16,
    parameter int NREG = 4,
    localparam int IDXW  = $clog2(MVL),
    localparam int RW    = $clog2(NREG),
    localparam int DEPTH = NREG * MVL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   wreg,
    input  logic [IDXW-1:0] widx,
    input  logic [EW-1:0]   wdata,
    input  logic [RW-1:0]   a_reg,
    input  logic [IDXW-1:0] a_idx,
    output logic [EW-1:0]   a_data,
    input  logic [RW-1:0]   b_reg,
    input  logic [IDXW-1:0] b_idx,
    output logic [EW-1:0]   b_data,
    input  logic [RW-1:0]   h_reg,
    input  logic [IDXW-1:0] h_idx,
    output logic [EW-1:0]   h_data
);

    logic [EW-1:0] mem [DEPTH];

    // Clear all storage on reset, otherwise take the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[{wreg, widx}] <= wdata;
        end
    end

    assign a_data = mem[{a_reg, a_idx}];
    assign b_data = mem[{b_reg, b_idx}];
    assign h_data = mem[{h_reg, h_idx}];

endmodule

// File: rtl/vmask_seq.sv
`timescale 1ns/1ps
// vmask_seq: element sequencer. Walks idx from 0 to len-1, one per cycle,
// then pulses done. A zero length or an instant command pulses done at once.
// Assumes go_vec and go_now are only raised while busy is low.
module vmask_seq #(
    parameter int MVL = 64,
    localparam int IDXW = $clog2(MVL),
    localparam int VLW  = $clog2(MVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_vec,
    input  logic            go_now,
    input  logic [VLW-1:0]  go_len,
    output logic            busy,
    output logic [IDXW-1:0] idx,
    output logic            last,
    output logic            done
);

    logic [VLW-1:0] len_q;

    assign last = busy && (VLW'(idx) == (len_q - VLW'(1)));

    // Start, advance and finish an element run; generate the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx   <= '0;
            len_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go_now) begin
                done <= 1'b1;
            end else if (go_vec) begin
                len_q <= go_len;
                idx   <= '0;
                if (go_len == '0) done <= 1'b1;
                else              busy <= 1'b1;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R7: the running index never reaches the run length.
    p_idx_in_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (VLW'(idx) < len_q));

    // R9: completing the final element is followed by done with busy low.
    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (done && !busy));

endmodule

// File: rtl/vmask_unit.sv
`timescale 1ns/1ps
// vmask_unit: mask register plus element-serial integer vector engine.
// Compares fill the mask one bit per element; masked arithmetic writes only
// elements with a set mask bit but still spends a cycle on every element.
// Assumes EW <= MVL, and that NREG and MVL are powers of two.
module vmask_unit
    import vmask_pkg::*;
#(
    parameter int MVL  = 64,
    parameter int EW   = 16,
    parameter int NREG = 4,
    localparam int IDXW = $clog2(MVL),
    localparam int VLW  = $clog2(MVL + 1),
    localparam int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic [2:0]      cmd_cond,
    input  logic            cmd_masked,
    input  logic [RW-1:0]   cmd_vd,
    input  logic [RW-1:0]   cmd_va,
    input  logic [RW-1:0]   cmd_vb,
    input  logic [MVL-1:0]  cmd_scalar,
    output logic            busy,
    output logic            done,
    output logic [MVL-1:0]  mask_q,
    output logic [VLW-1:0]  vl_q,
    input  logic            host_we,
    input  logic [RW-1:0]   host_reg,
    input  logic [IDXW-1:0] host_idx,
    input  logic [EW-1:0]   host_wdata,
    input  logic [RW-1:0]   host_rreg,
    input  logic [IDXW-1:0] host_ridx,
    output logic [EW-1:0]   host_rdata
);

    vop_e            acc_op;
    logic            known_op;
    logic            accept;
    logic            go_vec;
    logic            go_now;

    vop_e            op_q;
    logic [2:0]      cond_q;
    logic            masked_q;
    logic [RW-1:0]   vd_q;
    logic [RW-1:0]   va_q;
    logic [RW-1:0]   vb_q;
    logic [EW-1:0]   scal_q;

    logic [IDXW-1:0] idx;
    logic            last;
    logic [EW-1:0]   opa;
    logic [EW-1:0]   rfb;
    logic [EW-1:0]   opb;
    logic [EW-1:0]   alu_y;
    logic            cmp_hit;
    logic            elem_on;
    logic            eng_we;

    logic            rf_we;
    logic [RW-1:0]   rf_wreg;
    logic [IDXW-1:0] rf_widx;
    logic [EW-1:0]   rf_wdata;

    assign acc_op   = vop_e'(cmd_op);
    assign known_op = (cmd_op <= 4'd8);
    assign accept   = cmd_valid && !busy && known_op;
    assign go_vec   = accept && (op_is_arith(acc_op) || op_is_cmp(acc_op));
    assign go_now   = accept && !(op_is_arith(acc_op) || op_is_cmp(acc_op));

    // Capture the command fields that the element run needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_VADD;
            cond_q   <= '0;
            masked_q <= 1'b0;
            vd_q     <= '0;
            va_q     <= '0;
            vb_q     <= '0;
            scal_q   <= '0;
        end else if (accept) begin
            op_q     <= acc_op;
            cond_q   <= cmd_cond;
            masked_q <= cmd_masked;
            vd_q     <= cmd_vd;
            va_q     <= cmd_va;
            vb_q     <= cmd_vb;
            scal_q   <= cmd_scalar[EW-1:0];
        end
    end

    vmask_seq #(.MVL(MVL)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_vec (go_vec),
        .go_now (go_now),
        .go_len (vl_q),
        .busy   (busy),
        .idx    (idx),
        .last   (last),
        .done   (done)
    );

    vmask_rf #(.MVL(MVL), .EW(EW), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .wreg   (rf_wreg),
        .widx   (rf_widx),
        .wdata  (rf_wdata),
        .a_reg  (va_q),
        .a_idx  (idx),
        .a_data (opa),
        .b_reg  (vb_q),
        .b_idx  (idx),
        .b_data (rfb),
        .h_reg  (host_rreg),
        .h_idx  (host_ridx),
        .h_data (host_rdata)
    );

    assign opb = op_uses_scalar(op_q) ? scal_q : rfb;

    vmask_alu #(.EW(EW)) u_alu (
        .a   (opa),
        .b   (opb),
        .sub (op_is_sub(op_q)),
        .y   (alu_y)
    );

    vmask_cmp #(.EW(EW)) u_cmp (
        .lhs  (opa),
        .rhs  (opb),
        .cond (cond_q),
        .hit  (cmp_hit)
    );

    // Element write enable: the mask gates only when masking was requested.
    assign elem_on = !masked_q || mask_q[idx];
    assign eng_we  = busy && op_is_arith(op_q) && elem_on;

    // Write port arbitration: engine first, host only while idle.
    always_comb begin
        if (eng_we) begin
            rf_we    = 1'b1;
            rf_wreg  = vd_q;
            rf_widx  = idx;
            rf_wdata = alu_y;
        end else begin
            rf_we    = host_we && !busy;
            rf_wreg  = host_reg;
            rf_widx  = host_idx;
            rf_wdata = host_wdata;
        end
    end

    // Mask register: clear, load, or per-element compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (accept && acc_op == OP_CLRM) begin
            mask_q <= '1;
        end else if (accept && acc_op == OP_MOVM) begin
            mask_q <= cmd_scalar;
        end else if (busy && op_is_cmp(op_q)) begin
            mask_q[idx] <= cmp_hit;
        end
    end

    // Vector length register, clamped to the register size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= VLW'(MVL);
        end else if (accept && acc_op == OP_SETVL) begin
            if (cmd_scalar > MVL'(MVL)) vl_q <= VLW'(MVL);
            else                        vl_q <= cmd_scalar[VLW-1:0];
        end
    end

    // R3: arithmetic runs never disturb the mask they are gated by.
    p_mask_hold_arith_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_is_arith(op_q)) |=> (mask_q == $past(mask_q)));

    // R5: a clear leaves every mask bit set.
    p_clear_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_op == OP_CLRM) |=> (&mask_q));

    // R6: a mask load copies the scalar verbatim.
    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_op == OP_MOVM) |=> (mask_q == $past(cmd_scalar)));

    // R8: the engine writes only below the active length.
    p_write_below_vl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (VLW'(idx) < vl_q));

    // R10: the length register never exceeds the register size.
    p_vl_capped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vl_q <= VLW'(MVL));

    // R12: length and mask-load commands are not taken during a run.
    p_vl_stable_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (vl_q == $past(vl_q)));

endmodule

// File: tb/sim_vmask_unit.sv
`timescale 1ns/1ps
module sim_vmask_unit;

    localparam int MVL  = 64;
    localparam int EW   = 16;
    localparam int NREG = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [3:0]      cmd_op = '0;
    logic [2:0]      cmd_cond = '0;
    logic            cmd_masked = 1'b0;
    logic [1:0]      cmd_vd = '0;
    logic [1:0]      cmd_va = '0;
    logic [1:0]      cmd_vb = '0;
    logic [63:0]     cmd_scalar = '0;
    logic            busy;
    logic            done;
    logic [63:0]     mask_q;
    logic [6:0]      vl_q;
    logic            host_we = 1'b0;
    logic [1:0]      host_reg = '0;
    logic [5:0]      host_idx = '0;
    logic [15:0]     host_wdata = '0;
    logic [1:0]      host_rreg = '0;
    logic [5:0]      host_ridx = '0;
    logic [15:0]     host_rdata;

    int checks = 0;
    int failures = 0;
    logic [15:0] m [NREG][MVL];
    logic [63:0] em;

    vmask_unit #(.MVL(MVL), .EW(EW), .NREG(NREG)) u0 (.*);

    always #2.5 clk = ~clk;

    // Compare table: {expected, cond, element, scalar}.
    localparam logic [35:0] CMP_TAB [12] = '{
        {1'b1, 3'd0, 16'h0005, 16'h0005},
        {1'b0, 3'd0, 16'h0005, 16'h0006},
        {1'b1, 3'd1, 16'h0005, 16'h0006},
        {1'b0, 3'd1, 16'h0007, 16'h0007},
        {1'b1, 3'd2, 16'h0009, 16'h0003},
        {1'b0, 3'd2, 16'h0003, 16'h0009},
        {1'b0, 3'd2, 16'h8000, 16'h0001},
        {1'b1, 3'd3, 16'hFFFF, 16'h0000},
        {1'b0, 3'd3, 16'h0004, 16'h0004},
        {1'b1, 3'd4, 16'h0004, 16'h0004},
        {1'b0, 3'd5, 16'h7FFF, 16'h8000},
        {1'b1, 3'd5, 16'h8000, 16'h7FFF}
    };

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] r, input logic [5:0] i, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_reg = r; host_idx = i; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        m[r][i] = d;
    endtask

    task automatic cmd(input logic [3:0] op, input logic [2:0] cc, input logic mk,
                       input logic [1:0] vd, input logic [1:0] va, input logic [1:0] vb,
                       input logic [63:0] sc, output int cyc, output logic saw);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cond = cc; cmd_masked = mk;
        cmd_vd = vd; cmd_va = va; cmd_vb = vb; cmd_scalar = sc;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0; saw = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done) begin saw = 1'b1; break; end
            if (busy) cyc++;
            @(negedge clk);
        end
    endtask

    function automatic logic mcmp(input logic [15:0] a, input logic [15:0] b, input int c);
        int sa;
        int sb;
        sa = int'($signed(a));
        sb = int'($signed(b));
        case (c)
            0: return sa == sb;
            1: return sa != sb;
            2: return sa > sb;
            3: return sa < sb;
            4: return sa >= sb;
            default: return sa <= sb;
        endcase
    endfunction

    task automatic check_reg(input logic [1:0] r, input string req);
        int bad;
        logic [15:0] act;
        logic [15:0] exp;
        bad = -1;
        act = '0;
        exp = '0;
        for (int i = 0; i < MVL; i++) begin
            host_rreg = r; host_ridx = 6'(i);
            #0.1;
            if (host_rdata !== m[r][i] && bad < 0) begin
                bad = i; act = host_rdata; exp = m[r][i];
            end
        end
        chk(bad < 0, req, 64'(act), 64'(exp));
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        logic saw;
        for (int r = 0; r < NREG; r++)
            for (int i = 0; i < MVL; i++) m[r][i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk(mask_q === '1, "R10 mask reset", mask_q, '1);
        chk(vl_q === 7'd64, "R10 vl reset", 64'(vl_q), 64);
        chk(busy === 1'b0 && done === 1'b0, "R10 idle reset", {busy, done}, 0);
        check_reg(2'd0, "R10 storage reset");

        // R1 R2 R8: table-driven scalar compares at length 1
        cmd(4'd8, 3'd0, 1'b0, 0, 0, 0, 64'd1, cyc, saw);
        for (int t = 0; t < 12; t++) begin
            hw(2'd0, 6'd0, CMP_TAB[t][31:16]);
            cmd(4'd5, CMP_TAB[t][34:32], 1'b0, 0, 0, 0, 64'(CMP_TAB[t][15:0]), cyc, saw);
            chk(mask_q[0] === CMP_TAB[t][35], "R2 compare table", 64'(mask_q[0]), 64'(CMP_TAB[t][35]));
            chk(mask_q[63:1] === '1, "R8 mask above length", 64'(mask_q[63:1]), 64'h7FFF_FFFF_FFFF_FFFF);
        end

        // R1 R3 R4 R7 R8 R9: X = X - Y only where X != 0, length 8
        cmd(4'd6, 3'd0, 1'b0, 0, 0, 0, 64'd0, cyc, saw);
        chk(mask_q === '1, "R5 clear", mask_q, '1);
        cmd(4'd8, 3'd0, 1'b0, 0, 0, 0, 64'd8, cyc, saw);
        hw(0, 0, 16'd3); hw(0, 1, 16'd0); hw(0, 2, 16'd10); hw(0, 3, 16'd0);
        hw(0, 4, 16'd0); hw(0, 5, 16'd7); hw(0, 6, 16'd1); hw(0, 7, 16'd0);
        hw(0, 8, 16'h0055);
        for (int i = 0; i < 9; i++) hw(2'd1, 6'(i), 16'(i + 1));
        cmd(4'd5, 3'd1, 1'b0, 0, 0, 0, 64'd0, cyc, saw);
        em = '1;
        for (int i = 0; i < 8; i++) em[i] = (m[0][i] != 16'd0);
        chk(mask_q === em, "R1 not-equal-zero mask", mask_q, em);
        cmd(4'd1, 3'd0, 1'b1, 0, 0, 1, 64'd0, cyc, saw);
        chk(cyc == 8, "R7 masked run length", 64'(cyc), 8);
        chk(saw === 1'b1, "R9 done seen", 64'(saw), 1);
        @(negedge clk);
        chk(done === 1'b0, "R9 done single cycle", 64'(done), 0);
        for (int i = 0; i < 8; i++) if (em[i]) m[0][i] = m[0][i] - m[1][i];
        check_reg(2'd0, "R3 R4 R8 masked subtract");

        // R4: unmasked add ignores the zero mask bits
        cmd(4'd0, 3'd0, 1'b0, 2, 0, 1, 64'd0, cyc, saw);
        for (int i = 0; i < 8; i++) m[2][i] = m[0][i] + m[1][i];
        check_reg(2'd2, "R4 unmasked add");

        // R6 R11 R3: mask load then masked add of scalar with wrap
        cmd(4'd7, 3'd0, 1'b0, 0, 0, 0, 64'hA5A5_0000_FFFF_0F0F, cyc, saw);
        chk(mask_q === 64'hA5A5_0000_FFFF_0F0F, "R6 mask load", mask_q, 64'hA5A5_0000_FFFF_0F0F);
        cmd(4'd2, 3'd0, 1'b1, 3, 1, 0, 64'h7FFF, cyc, saw);
        chk(cyc == 8, "R7 run length with sparse mask", 64'(cyc), 8);
        for (int i = 0; i < 8; i++) if (mask_q[i]) m[3][i] = m[1][i] + 16'h7FFF;
        check_reg(2'd3, "R3 R11 masked scalar add");

        // R11: unmasked scalar subtract wraps below zero
        cmd(4'd3, 3'd0, 1'b0, 3, 3, 0, 64'd1, cyc, saw);
        for (int i = 0; i < 8; i++) m[3][i] = m[3][i] - 16'd1;
        check_reg(2'd3, "R11 subtract wrap");

        // R1 R5: vector-vector greater-than after a clear
        cmd(4'd6, 3'd0, 1'b0, 0, 0, 0, 64'd0, cyc, saw);
        cmd(4'd4, 3'd2, 1'b1, 0, 0, 1, 64'd0, cyc, saw);
        em = '1;
        for (int i = 0; i < 8; i++) em[i] = mcmp(m[0][i], m[1][i], 2);
        chk(mask_q === em, "R1 vector compare", mask_q, em);

        // R10 R9: length clamp, then zero length run
        cmd(4'd8, 3'd0, 1'b0, 0, 0, 0, 64'd100, cyc, saw);
        chk(vl_q === 7'd64, "R10 length clamp", 64'(vl_q), 64);
        cmd(4'd8, 3'd0, 1'b0, 0, 0, 0, 64'd0, cyc, saw);
        cmd(4'd0, 3'd0, 1'b0, 2, 1, 1, 64'd0, cyc, saw);
        chk(cyc == 0 && saw === 1'b1, "R9 zero length", 64'(cyc), 0);
        check_reg(2'd2, "R9 zero length no write");

        // R12: command and host write during a full-length run
        cmd(4'd8, 3'd0, 1'b0, 0, 0, 0, 64'd64, cyc, saw);
        cmd(4'd7, 3'd0, 1'b0, 0, 0, 0, 64'd0, cyc, saw);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd0; cmd_masked = 1'b0;
        cmd_vd = 2; cmd_va = 1; cmd_vb = 1;
        @(negedge clk);
        cmd_op = 4'd6;
        host_we = 1'b1; host_reg = 2'd3; host_idx = 6'd63; host_wdata = 16'h1234;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0; host_we = 1'b0;
        for (int k = 0; k < 100 && !done; k++) @(negedge clk);
        chk(mask_q === 64'd0, "R12 command ignored while busy", mask_q, 0);
        for (int i = 0; i < MVL; i++) m[2][i] = m[1][i] + m[1][i];
        check_reg(2'd3, "R12 host write ignored while busy");
        check_reg(2'd2, "R4 full length unmasked add");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule